// File: doc/BRIEF.md
# Prescaled serial baud generator

This block makes the timing ticks for an asynchronous serial port out of the peripheral clock. A 2-bit select code picks a power-of-four prescale factor, and an 8-bit divisor N sets a further division by N+1. Together they give a sample tick at sixteen times the bit rate and a bit tick once per bit time. One bit time is 32 · 4^sel · (N+1) peripheral clocks, which is the bit rate B = Pf / (32 · prescale · (N+1)). The transmitter and the receiver shifters use the two ticks directly.

The generator runs only while at least one of the transmit or receive enables is high. When both are low, every counter is held cleared and no tick is produced. New select and divisor values are presented with a one-cycle load strobe. They are held pending and applied at the next prescaler wrap, or at once while the generator is idle. Applying them restarts the divider chain from the top, so no shortened tick is ever emitted.

Top module: `baud_gen`

## Requirements
- R1: Select code 0, 1, 2 and 3 gives a prescale factor of 1, 4, 16 and 64 peripheral clocks per prescaler wrap.
- R2: While running, `sample_tick` pulses once every 2 · 4^sel · (N+1) clocks.
- R3: While running, `bit_tick` pulses once every 32 · 4^sel · (N+1) clocks, which is every 16th sample tick. It is high only in a cycle where `sample_tick` is also high.
- R4: The period formulas hold at both divisor extremes, N = 0 and N = 255.
- R5: While `tx_en` and `rx_en` are both low, neither tick is ever asserted. Raising either enable alone starts the ticks.
- R6: A load while running takes effect at the next prescaler wrap and restarts the divider chain. The gap from the last tick before the load to the first tick after it is at least one new sample period, and later ticks follow the new period exactly.
- R7: During reset and after reset both ticks are low. The default configuration is select 0 and divisor 0.
- R8: Each tick is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; runs the generator |
| rx_en | input | 1 | Receive enable; runs the generator |
| cfg_load | input | 1 | One-cycle strobe that captures cfg_sel and cfg_div |
| cfg_sel | input | 2 | Prescale select code (factor 4^code) |
| cfg_div | input | 8 | Divisor N; the divider divides by N+1 |
| sample_tick | output | 1 | 16x oversampling tick, one cycle wide |
| bit_tick | output | 1 | One pulse per bit time, one cycle wide |

## Verification
The bench measures tick spacing for every select code and at N = 0 and N = 255. An off-by-one in the reload value would show up as periods based on N instead of N+1, and a wrong prescale shift would scale every period by the wrong factor. It reloads the configuration while running and checks that the first gap is not shorter than the new period. A design that applied the load mid-count would emit a shortened tick there. It also holds both enables low and counts ticks, where a design that did not gate its counters would keep ticking. The single-enable cases show whether one enable alone fails to start the counters.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int SEL_W   = 2;
  localparam int DIV_W   = 8;
  localparam int PRE_W   = 2 * ((1 << SEL_W) - 1);
  localparam int OSR     = 16;
  localparam int SUB_DIV = 2;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [SW-1:0] sel,
  output logic          wrap
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] limit;

  always_comb limit = {PW{1'b1}} >> (PW - 2 * int'(sel));

  assign wrap = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || wrap) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  p_pre_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));
endmodule

// File: rtl/baud_divider.sv
module baud_divider
  import baud_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic          restart,
  input  logic [DW-1:0] reload,
  output logic          pulse
);
  logic [DW-1:0] dcnt;

  assign pulse = step && (dcnt == '0) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dcnt <= '0;
    else if (!run)              dcnt <= reload;
    else if (step) begin
      if (restart || dcnt == '0) dcnt <= reload;
      else                      dcnt <= dcnt - 1'b1;
    end
  end

  p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step && !restart) |=> $stable(dcnt));
endmodule

// File: rtl/baud_oversample.sv
module baud_oversample
  import baud_pkg::*;
#(
  parameter int RATIO = OSR,
  parameter int SUB   = SUB_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic step,
  output logic samp,
  output logic bitt
);
  localparam int SUB_CW = (SUB > 1) ? $clog2(SUB) : 1;
  localparam int OSR_CW = $clog2(RATIO);
  localparam logic [SUB_CW-1:0] SUB_LAST = SUB_CW'(SUB - 1);
  localparam logic [OSR_CW-1:0] OSR_LAST = OSR_CW'(RATIO - 1);

  logic [SUB_CW-1:0] sub;
  logic [OSR_CW-1:0] scnt;

  assign samp = step && (sub == SUB_LAST);
  assign bitt = samp && (scnt == OSR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub  <= '0;
      scnt <= '0;
    end else if (!run || restart) begin
      sub  <= '0;
      scnt <= '0;
    end else if (step) begin
      sub <= samp ? '0 : sub + 1'b1;
      if (samp) scnt <= bitt ? '0 : scnt + 1'b1;
    end
  end

  p_sample_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !samp) |=> $stable(scnt));
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             cfg_load,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             sample_tick,
  output logic             bit_tick
);
  logic             run;
  logic             pre_wrap;
  logic             apply;
  logic             pend_flag;
  logic [SEL_W-1:0] pend_sel, act_sel;
  logic [DIV_W-1:0] pend_div, act_div;
  logic [DIV_W-1:0] div_reload;
  logic             div_pulse;
  logic             samp_c, bit_c;

  assign run        = tx_en | rx_en;
  assign apply      = pend_flag && (pre_wrap || !run);
  assign div_reload = apply ? pend_div : act_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_flag <= 1'b0;
      pend_sel  <= '0;
      pend_div  <= '0;
      act_sel   <= '0;
      act_div   <= '0;
    end else begin
      if (apply) begin
        act_sel <= pend_sel;
        act_div <= pend_div;
      end
      if (cfg_load) begin
        pend_sel  <= cfg_sel;
        pend_div  <= cfg_div;
        pend_flag <= 1'b1;
      end else if (apply) begin
        pend_flag <= 1'b0;
      end
    end
  end

  baud_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (act_sel),
    .wrap (pre_wrap)
  );

  baud_divider u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .step   (pre_wrap),
    .restart(apply),
    .reload (div_reload),
    .pulse  (div_pulse)
  );

  baud_oversample u_ovs (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .restart(apply),
    .step   (div_pulse),
    .samp   (samp_c),
    .bitt   (bit_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      sample_tick <= run && samp_c;
      bit_tick    <= run && bit_c;
    end
  end

  p_bit_in_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sample_tick && !bit_tick));
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);
  p_wait_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_flag && run && !pre_wrap) |=> pend_flag);
endmodule

// File: tb/sim_baud_gen.sv
`timescale 1ns/1ps
module sim_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, rx_en = 1'b0, cfg_load = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_div = '0;
  logic       sample_tick, bit_tick;
  int         cyc = 0;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_gen u0 (.*);

  localparam int NV = 8;
  localparam int T_SEL [NV] = '{0, 0, 1, 1, 2, 3, 0, 3};
  localparam int T_DIV [NV] = '{0, 5, 0, 3, 1, 0, 255, 255};
  localparam int T_SP  [NV] = '{2, 12, 8, 32, 64, 128, 512, 32768};
  localparam int T_BP  [NV] = '{32, 192, 128, 512, 1024, 2048, 8192, 0};
  localparam int T_EN  [NV] = '{1, 2, 3, 1, 2, 3, 1, 2};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_s();
    @(negedge clk);
    while (!sample_tick) @(negedge clk);
  endtask

  task automatic wait_b();
    @(negedge clk);
    while (!bit_tick) @(negedge clk);
  endtask

  task automatic load(input int s, input int d);
    @(negedge clk);
    cfg_sel = 2'(s); cfg_div = 8'(d); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic idle_count(input int n, output int ticks);
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sample_tick || bit_tick) ticks++;
    end
  endtask

  initial begin
    #1500000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t0, g, k;
    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 sample_tick in reset", int'(sample_tick), 0);
    chk("R7 bit_tick in reset", int'(bit_tick), 0);
    rst_n = 1'b1;
    idle_count(50, k);
    chk("R5 idle after reset", k, 0);

    // R7: default configuration select 0, N 0 gives period 2
    tx_en = 1'b1;
    wait_s(); t0 = cyc; wait_s(); g = cyc - t0;
    chk("R7 default sample period", g, 2);
    tx_en = 1'b0;

    for (int v = 0; v < NV; v++) begin
      load(T_SEL[v], T_DIV[v]);
      idle_count(40, k);
      chk("R5 no ticks while disabled", k, 0);
      tx_en = T_EN[v][0];
      rx_en = T_EN[v][1];
      wait_s(); t0 = cyc; wait_s(); g = cyc - t0;
      chk((T_DIV[v] == 0 || T_DIV[v] == 255) ? "R4 sample period" : "R2 sample period",
          g, T_SP[v]);
      chk("R1 prescale factor", g / (2 * (T_DIV[v] + 1)), 1 << (2 * T_SEL[v]));
      // R8: one cycle wide
      @(negedge clk);
      chk("R8 sample pulse width", int'(sample_tick), (T_SP[v] == 1) ? 1 : 0);
      if (T_BP[v] != 0) begin
        wait_b(); t0 = cyc; wait_b(); g = cyc - t0;
        chk("R3 bit period", g, T_BP[v]);
        chk("R3 bit with sample", int'(sample_tick), 1);
        @(negedge clk);
        chk("R8 bit pulse width", int'(bit_tick), 0);
      end
      tx_en = 1'b0; rx_en = 1'b0;
    end

    // R6: reload while running
    load(0, 3);
    rx_en = 1'b1;
    wait_s(); wait_s();
    t0 = cyc;
    cfg_sel = 2'd1; cfg_div = 8'd2; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    while (!sample_tick) @(negedge clk);
    g = cyc - t0;
    chk("R6 no short tick after reload", (g >= 24) ? 1 : 0, 1);
    t0 = cyc; wait_s(); g = cyc - t0;
    chk("R6 new period after reload", g, 24);
    rx_en = 1'b0;
    idle_count(30, k);
    chk("R5 quiet after disable", k, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule